// File: doc/BRIEF.md
# Slow-to-Fast Clock Ratio Counter

This block measures how fast a crystal reference clock runs compared with a slow low-power oscillator. While measurement is enabled, it counts reference-clock cycles across four consecutive periods of the slow clock. It then latches that count where software can read it. Software converts the count to a frequency. At nominal rates of 32768 Hz for the slow clock and 20 MHz for the fast clock, a window holds about 2441 counts.

The block runs entirely in the fast clock domain:

- **Slow clock input.** The slow clock arrives as an asynchronous input. A two-flop synchroniser brings it into the fast domain, and the block counts rising edges of the synchronised signal.
- **Register port.** A plain register port (write strobe, 32-bit write data, 32-bit read data) controls a run/stop bit and returns the latched count.
- **Availability.** A status output reports whether the external oscillator is present. No measurement runs while it is absent.

Software clears the run/stop bit when no measurement is needed, so the counting logic stops switching.

Top module: `ratio_meter`

## Requirements
- R1: A write with `reg_wdata[31]` = 1 enables measurement and a write with it = 0 disables it; `reg_rdata[31]` returns the current enable state.
- R2: While enabled and the oscillator is available, the count is latched at the end of each window. The count equals the number of fast-clock cycles between the synchronised slow rising edge that opens the window and the fourth rising edge after it. For a slow period of P fast cycles, this is 4*P.
- R3: The latched count reads back in `reg_rdata[12:0]`. Each closing edge also opens the next window at once, so the value refreshes every four slow periods for as long as measurement stays enabled.
- R4: The count saturates at 8191 instead of wrapping; a window longer than 8191 fast cycles latches 8191.
- R5: `reg_rdata[30:13]` always reads zero.
- R6: While disabled, the window counter is held at zero and the latched value keeps its contents.
- R7: While the oscillator-available input is low, no window opens or closes and the latched value keeps its contents.
- R8: `status[8]` follows the oscillator-available input one cycle later; all other status bits read zero.
- R9: Reset clears the enable bit, the counter, the latched value and the status output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Asynchronous slow oscillator |
| osc_avail | input | 1 | External slow oscillator present |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data (bit 31 = enable) |
| reg_rdata | output | 32 | {enable, 18 zeros, latched count} |
| status | output | 16 | Bit 8 = oscillator available |

## Verification
The bench sweeps the slow-clock period across a range of values:

- **Short periods (2, 3, 5 cycles).** These tell apart an off-by-one in window framing and edge detection that misses back-to-back edges.
- **Mid-range periods near the nominal ratio.** These confirm the 4*P arithmetic.
- **Periods of 2047, 2048 and 3000.** These sit on both sides of the 13-bit limit and separate saturation from wrapping.

Separate phases lower the availability input or clear the enable bit while the slow period changes. If the latched value stayed put, no window ran in those phases.

// File: rtl/ratio_pkg.sv
package ratio_pkg;
  localparam int CNT_W        = 13;
  localparam int DATA_W       = 32;
  localparam int STAT_W       = 16;
  localparam int EN_BIT       = 31;
  localparam int AVAIL_BIT    = 8;
  localparam int WIN_EDGES    = 4;
  localparam int SYNC_STAGES  = 2;

  typedef enum logic {
    SEQ_WAIT = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ratio_edge_sync.sv
module ratio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[DEPTH-2:0], async_i};
  end

  // Rising edge seen after the synchroniser stages
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/ratio_window_seq.sv
module ratio_window_seq
  import ratio_pkg::*;
#(
  parameter int EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic rise_i,
  output logic open_o,
  output logic close_o,
  output logic active_o
);
  localparam int EW = (EDGES > 2) ? $clog2(EDGES) : 1;
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  seq_state_e      state_q;
  logic [EW-1:0]   ecnt_q;

  assign open_o   = run_i && rise_i && (state_q == SEQ_WAIT);
  assign close_o  = run_i && rise_i && (state_q == SEQ_RUN) && (ecnt_q == LAST);
  assign active_o = (state_q == SEQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_WAIT;
      ecnt_q  <= '0;
    end else if (!run_i) begin
      state_q <= SEQ_WAIT;
      ecnt_q  <= '0;
    end else if (open_o) begin
      state_q <= SEQ_RUN;
      ecnt_q  <= '0;
    end else if (close_o) begin
      ecnt_q  <= '0;
    end else if (active_o && rise_i) begin
      ecnt_q  <= ecnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ratio_sat_counter.sv
module ratio_sat_counter #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] next_o
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] cnt_q;

  assign next_o  = (cnt_q == MAXV) ? MAXV : cnt_q + 1'b1;
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (inc_i)    cnt_q <= next_o;
  end
endmodule

// File: rtl/ratio_meter.sv
module ratio_meter
  import ratio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              osc_avail,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [STAT_W-1:0] status
);
  localparam int PAD_W = DATA_W - CNT_W - 1;

  logic             en_q;
  logic             run;
  logic             rise;
  logic             win_open, win_close, win_active;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic [CNT_W-1:0] latch_q;
  logic             avail_q;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[EN_BIT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (reg_we) en_q <= reg_wdata[EN_BIT];
  end

  assign run = en_q & osc_avail;

  ratio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (slow_clk),
    .rise_o  (rise)
  );

  ratio_window_seq #(.EDGES(WIN_EDGES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .rise_i   (rise),
    .open_o   (win_open),
    .close_o  (win_close),
    .active_o (win_active)
  );

  ratio_sat_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (!run || win_open || win_close),
    .inc_i   (win_active),
    .count_o (cnt_q),
    .next_o  (cnt_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latch_q <= '0;
    else if (win_close) latch_q <= cnt_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avail_q <= 1'b0;
    else        avail_q <= osc_avail;
  end

  always_comb begin
    status            = '0;
    status[AVAIL_BIT] = avail_q;
  end

  assign reg_rdata = {en_q, {PAD_W{1'b0}}, latch_q};
endmodule

// File: rtl/ratio_meter_chk.sv
module ratio_meter_chk #(
  parameter int CNT_W  = 13,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              avail_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  latch_i,
  input logic [DATA_W-1:0] rdata_i
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_i[DATA_W-2:CNT_W] == '0); // R5

  AST_IDLE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && $past(!en_i)) |-> cnt_i == '0); // R6

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(latch_i)); // R6

  AST_NO_OSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !avail_i |=> $stable(latch_i)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == MAXV) |=> (cnt_i == MAXV || cnt_i == '0)); // R4
endmodule

bind ratio_meter ratio_meter_chk #(
  .CNT_W  (ratio_pkg::CNT_W),
  .DATA_W (ratio_pkg::DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (en_q),
  .avail_i (osc_avail),
  .cnt_i   (cnt_q),
  .latch_i (latch_q),
  .rdata_i (reg_rdata)
);

// File: tb/sim_ratio_meter.sv
`timescale 1ns/1ps
module sim_ratio_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        osc_avail = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] status;

  int n_chk = 0;
  int n_fail = 0;
  int period = 10;
  int phase = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ratio_meter u0 (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .osc_avail(osc_avail),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status(status)
  );

  // Slow clock generator: rising edge every `period` fast cycles
  always @(negedge clk) begin
    phase    <= (phase + 1 >= period) ? 0 : phase + 1;
    slow_clk <= (phase < period / 2);
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [31:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic measure(input int p);
    int exp;
    reg_write(32'h0);
    period = p;
    wait_cycles(4);
    reg_write(32'h8000_0000);
    wait_cycles(1);
    check("R1 enable readback", reg_rdata[31], 1);
    check("R5 reserved zero", reg_rdata[30:13], 0);
    wait_cycles(6 * p + 20);
    exp = (4 * p > 8191) ? 8191 : 4 * p;
    if (4 * p > 8191) check("R4 saturation", reg_rdata[12:0], exp);
    else              check("R2 four-period count", reg_rdata[12:0], exp);
    wait_cycles(4 * p + 4);
    check("R3 repeated window", reg_rdata[12:0], exp);
  endtask

  initial begin
    int periods [11] = '{2, 3, 5, 8, 13, 100, 611, 1000, 2047, 2048, 3000};
    wait_cycles(3);
    check("R9 reset rdata", reg_rdata, 0);
    check("R9 reset status", status, 0);
    rst_n = 1'b1;
    osc_avail = 1'b1;
    wait_cycles(3);
    check("R8 status avail high", status, 16'h0100);
    foreach (periods[i]) measure(periods[i]);
    // R7: oscillator absent, no window runs
    reg_write(32'h0);
    osc_avail = 1'b0;
    period = 7;
    wait_cycles(5);
    check("R8 status avail low", status, 0);
    reg_write(32'h8000_0000);
    wait_cycles(100);
    check("R7 latch held without osc", reg_rdata[12:0], 8191);
    osc_avail = 1'b1;
    wait_cycles(100);
    check("R7 measure after osc returns", reg_rdata[12:0], 28);
    // R6: disabled, latch keeps value across a period change
    reg_write(32'h0);
    period = 9;
    wait_cycles(120);
    check("R1 disable readback", reg_rdata[31], 0);
    check("R6 latch held when off", reg_rdata[12:0], 28);
    reg_write(32'h8000_0000);
    wait_cycles(80);
    check("R2 re-enable new period", reg_rdata[12:0], 36);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule